// File: doc/BRIEF.md
# Virtual Output Queue Input Port

This block is the receive side of one port of a four-output cell switch. Packets of a fixed length arrive as 4-bit nibbles, one nibble per accepted cycle, on the core clock. The first nibble is a destination address. That address indexes a routing table that is loaded serially, and the entry read gives the output port. A bit of the second nibble gives the priority. The whole packet goes into one buffer, drawn from a pool shared by all eight logical queues (one per output and priority). Each queue is a linked list of buffers.

An external scheduler sees one non-empty flag per queue. It names a queue with a grant. On the cycle after an accepted grant, the port streams the head packet of that queue out as nibbles, header included. The buffer returns to the pool only after its last nibble has gone out. Upstream traffic is throttled at packet boundaries through a ready signal.

Top module: `voq_input_port`

## Requirements
- R1: While reset is held and right after it, in_ready, out_valid and every q_nonempty bit are low.
- R2: The routing table is loaded by 32 cycles with tbl_shift_en high. in_ready stays low until all 32 shifts have been applied. The first bit shifted in becomes bit 0 of entry 0, and later bits fill entries 0 to 15 in turn, low bit first.
- R3: A packet is placed in queue number 2*table[dest] + prio. dest is nibble 0, and prio is bit 0 of nibble 1 (1 means high priority). q_nonempty bit q and grant_q value q both use this numbering.
- R4: q_nonempty[q] goes high in the cycle after the edge that accepts the eighth (last) nibble of a packet for queue q. It goes low after the edge that accepts the grant taking the queue's last packet.
- R5: When a grant is accepted at a clock edge, out_valid is high from the next cycle for exactly 8 cycles. out_nib carries the packet's nibbles in arrival order, and out_valid then falls unless a chained grant was accepted.
- R6: Each queue returns its packets in the order they were stored.
- R7: A grant is ignored when the named queue is empty, or when a transmission is running and is not in its last nibble cycle. out_valid and the packet in flight do not change, and the named queue keeps its packets.
- R8: A nibble is accepted on a cycle with in_valid and in_ready both high, and idle cycles may appear between nibbles. The pool holds 16 packets. When all 16 buffers are in use, in_ready is low at a packet boundary. Once the first nibble of a packet is accepted, in_ready stays high until its last nibble.
- R9: A buffer is released only after its last nibble has been presented. With the pool full, in_ready stays low throughout a transmission and rises in the cycle after its last nibble.
- R10: A grant accepted during the last nibble cycle of a transmission starts the next packet in the following cycle, with no idle cycle between the two packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_shift_en | input | 1 | Shift one routing-table bit this cycle |
| tbl_shift_bit | input | 1 | Serial routing-table data |
| in_valid | input | 1 | Upstream nibble valid |
| in_nib | input | 4 | Upstream nibble |
| in_ready | output | 1 | Port can accept the nibble offered this cycle |
| q_nonempty | output | 8 | One flag per logical queue, queue 2*output+priority |
| grant_valid | input | 1 | Scheduler grant strobe |
| grant_q | input | 3 | Queue named by the grant |
| out_valid | output | 1 | Outgoing nibble valid |
| out_nib | output | 4 | Outgoing nibble |

## Verification
The assertions count buffers as taken when a first nibble is accepted, and as given back when a nibble is presented in the eighth position of an output run. This count is correct only if upstream offers whole packets, and only if the routing table is left alone once traffic has started. The stimulus therefore loads the table exactly once, before any packet, and always completes every packet it begins. Idle gaps between nibbles and grants to empty or busy queues are issued freely, because the port must tolerate them.

// File: rtl/voq_pkg.sv
package voq_pkg;
   localparam int unsigned DEF_NIB_W    = 4;
   localparam int unsigned DEF_PKT_NIBS = 8;
   localparam int unsigned DEF_N_OUT    = 4;
   localparam int unsigned DEF_N_PRIO   = 2;
   localparam int unsigned DEF_N_BUF    = 16;

   typedef enum logic {
      PRIO_LOW  = 1'b0,
      PRIO_HIGH = 1'b1
   } prio_e;
endpackage

// File: rtl/voq_route_table.sv
module voq_route_table #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned PORT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              shift_bit,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [PORT_W-1:0] rd_port,
   output logic              loaded
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned BITS  = DEPTH * PORT_W;
   localparam int unsigned CW    = $clog2(BITS + 1);

   logic [BITS-1:0] tbl_q;
   logic [CW-1:0]   cnt_q;

   // serial path enters at the top, so the first bit ends at bit 0
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl_q <= '0;
         cnt_q <= '0;
      end else if (shift_en) begin
         tbl_q <= {shift_bit, tbl_q[BITS-1:1]};
         if (cnt_q != CW'(BITS)) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign loaded  = (cnt_q == CW'(BITS));
   assign rd_port = tbl_q[rd_addr*PORT_W +: PORT_W];
endmodule

// File: rtl/voq_free_list.sv
module voq_free_list #(
   parameter int unsigned N_BUF = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     pop,
   input  logic                     push,
   input  logic [$clog2(N_BUF)-1:0] push_idx,
   output logic [$clog2(N_BUF)-1:0] head_idx,
   output logic                     avail
);
   localparam int unsigned BW = $clog2(N_BUF);
   localparam int unsigned CW = $clog2(N_BUF + 1);

   logic [BW-1:0] slot_q [N_BUF];
   logic [BW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [BW-1:0] step(input logic [BW-1:0] p);
      return (p == BW'(N_BUF - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(N_BUF); i++) slot_q[i] <= BW'(i);
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= CW'(N_BUF);
      end else begin
         if (pop) rd_q <= step(rd_q);
         if (push) begin
            slot_q[wr_q] <= push_idx;
            wr_q         <= step(wr_q);
         end
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   assign head_idx = slot_q[rd_q];
   assign avail    = (cnt_q != '0);
endmodule

// File: rtl/voq_queue_ctrl.sv
module voq_queue_ctrl #(
   parameter int unsigned N_Q   = 8,
   parameter int unsigned N_BUF = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     app_en,
   input  logic [$clog2(N_Q)-1:0]   app_q,
   input  logic [$clog2(N_BUF)-1:0] app_buf,
   input  logic                     pop_en,
   input  logic [$clog2(N_Q)-1:0]   pop_q,
   output logic [$clog2(N_BUF)-1:0] pop_buf,
   output logic [N_Q-1:0]           nonempty
);
   localparam int unsigned QW = $clog2(N_Q);
   localparam int unsigned BW = $clog2(N_BUF);
   localparam int unsigned CW = $clog2(N_BUF + 1);

   logic [BW-1:0]             nxt_q [N_BUF];
   logic [N_Q-1:0][BW-1:0]    head_w;
   logic [N_Q-1:0][BW-1:0]    tail_w;
   logic [N_Q-1:0][CW-1:0]    cnt_w;

   // link a new buffer behind the current tail of a non-empty list
   always_ff @(posedge clk) begin
      if (app_en && (cnt_w[app_q] != '0)) nxt_q[tail_w[app_q]] <= app_buf;
   end

   for (genvar g = 0; g < int'(N_Q); g++) begin : g_list
      logic [BW-1:0] hd, tl;
      logic [CW-1:0] n;
      logic          hit_a, hit_p;

      assign hit_a = app_en && (app_q == QW'(g));
      assign hit_p = pop_en && (pop_q == QW'(g)) && (n != '0);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hd <= '0;
            tl <= '0;
            n  <= '0;
         end else begin
            if (hit_p)                   hd <= (n == CW'(1)) ? app_buf : nxt_q[hd];
            else if (hit_a && n == '0)   hd <= app_buf;
            if (hit_a) tl <= app_buf;
            n <= n + CW'(hit_a) - CW'(hit_p);
         end
      end

      assign head_w[g]   = hd;
      assign tail_w[g]   = tl;
      assign cnt_w[g]    = n;
      assign nonempty[g] = (n != '0);
   end

   assign pop_buf = head_w[pop_q];
endmodule

// File: rtl/voq_input_port.sv
module voq_input_port
   import voq_pkg::*;
#(
   parameter int unsigned NIB_W    = DEF_NIB_W,
   parameter int unsigned PKT_NIBS = DEF_PKT_NIBS,
   parameter int unsigned N_OUT    = DEF_N_OUT,
   parameter int unsigned N_PRIO   = DEF_N_PRIO,
   parameter int unsigned N_BUF    = DEF_N_BUF
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              tbl_shift_en,
   input  logic                              tbl_shift_bit,
   input  logic                              in_valid,
   input  logic [NIB_W-1:0]                  in_nib,
   output logic                              in_ready,
   output logic [N_OUT*N_PRIO-1:0]           q_nonempty,
   input  logic                              grant_valid,
   input  logic [$clog2(N_OUT*N_PRIO)-1:0]   grant_q,
   output logic                              out_valid,
   output logic [NIB_W-1:0]                  out_nib
);
   localparam int unsigned N_Q = N_OUT * N_PRIO;
   localparam int unsigned QW  = $clog2(N_Q);
   localparam int unsigned BW  = $clog2(N_BUF);
   localparam int unsigned IW  = $clog2(PKT_NIBS);
   localparam int unsigned PW  = $clog2(N_OUT);
   localparam int unsigned PRW = $clog2(N_PRIO);

   initial begin : param_checks
      assert (PKT_NIBS >= 3)
         else $fatal(1, "packet needs header, priority and at least one more nibble");
      assert (N_OUT >= 2 && (1 << PW) == N_OUT)
         else $fatal(1, "output count must be a power of two");
      assert (N_PRIO >= 2 && (1 << PRW) == N_PRIO && PRW <= NIB_W)
         else $fatal(1, "priority count must be a power of two that fits a nibble");
      assert (N_BUF >= 2)
         else $fatal(1, "pool needs at least two buffers");
   end

   // routing table
   logic          tbl_ok;
   logic [PW-1:0] lk_port;

   voq_route_table #(.ADDR_W(NIB_W), .PORT_W(PW)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (tbl_shift_en),
      .shift_bit (tbl_shift_bit),
      .rd_addr   (in_nib),
      .rd_port   (lk_port),
      .loaded    (tbl_ok)
   );

   // buffer pool
   logic          fl_pop, fl_push, fl_avail;
   logic [BW-1:0] fl_head, fl_ret;

   voq_free_list #(.N_BUF(N_BUF)) u_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop      (fl_pop),
      .push     (fl_push),
      .push_idx (fl_ret),
      .head_idx (fl_head),
      .avail    (fl_avail)
   );

   // receive side
   logic [IW-1:0]  rx_idx;
   logic [BW-1:0]  rx_buf, wr_buf;
   logic [PW-1:0]  rx_port;
   logic [PRW-1:0] rx_prio;
   logic           rx_first, rx_last, rx_acc;

   assign rx_first = (rx_idx == '0);
   assign rx_last  = (rx_idx == IW'(PKT_NIBS - 1));
   assign in_ready = rx_first ? (tbl_ok && fl_avail) : 1'b1;
   assign rx_acc   = in_valid && in_ready;
   assign wr_buf   = rx_first ? fl_head : rx_buf;
   assign fl_pop   = rx_acc && rx_first;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_idx  <= '0;
         rx_buf  <= '0;
         rx_port <= '0;
         rx_prio <= '0;
      end else if (rx_acc) begin
         rx_idx <= rx_last ? '0 : rx_idx + 1'b1;
         if (rx_first) begin
            rx_buf  <= fl_head;
            rx_port <= lk_port;
         end
         if (rx_idx == IW'(1)) rx_prio <= in_nib[PRW-1:0];
      end
   end

   // packet storage, one row of nibbles per buffer
   logic [NIB_W-1:0] pkt_mem [N_BUF][PKT_NIBS];

   always_ff @(posedge clk) begin
      if (rx_acc) pkt_mem[wr_buf][rx_idx] <= in_nib;
   end

   // queue lists
   logic          gnt_ok;
   logic [BW-1:0] q_head;

   voq_queue_ctrl #(.N_Q(N_Q), .N_BUF(N_BUF)) u_lists (
      .clk      (clk),
      .rst_n    (rst_n),
      .app_en   (rx_acc && rx_last),
      .app_q    ({rx_port, rx_prio}),
      .app_buf  (rx_buf),
      .pop_en   (gnt_ok),
      .pop_q    (grant_q),
      .pop_buf  (q_head),
      .nonempty (q_nonempty)
   );

   // transmit side
   logic          tx_on, tx_last, tx_free;
   logic [IW-1:0] tx_idx;
   logic [BW-1:0] tx_buf;

   assign tx_last = tx_on && (tx_idx == IW'(PKT_NIBS - 1));
   assign tx_free = !tx_on || tx_last;
   assign gnt_ok  = grant_valid && tx_free && q_nonempty[grant_q];
   assign fl_push = tx_last;
   assign fl_ret  = tx_buf;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_on  <= 1'b0;
         tx_idx <= '0;
         tx_buf <= '0;
      end else if (gnt_ok) begin
         tx_on  <= 1'b1;
         tx_idx <= '0;
         tx_buf <= q_head;
      end else if (tx_last) begin
         tx_on  <= 1'b0;
         tx_idx <= '0;
      end else if (tx_on) begin
         tx_idx <= tx_idx + 1'b1;
      end
   end

   assign out_valid = tx_on;
   assign out_nib   = tx_on ? pkt_mem[tx_buf][tx_idx] : '0;
endmodule

// File: rtl/voq_input_port_chk.sv
module voq_input_port_chk #(
   parameter int unsigned PKT_NIBS = 8,
   parameter int unsigned N_BUF    = 16,
   parameter int unsigned N_Q      = 8,
   parameter int unsigned TBL_BITS = 32,
   parameter int unsigned IW       = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   tbl_shift_en,
   input logic                   in_valid,
   input logic                   in_ready,
   input logic [IW-1:0]          rx_idx,
   input logic                   out_valid,
   input logic                   grant_valid,
   input logic [$clog2(N_Q)-1:0] grant_q,
   input logic [N_Q-1:0]         q_nonempty
);
   localparam int unsigned SCW = $clog2(TBL_BITS + 1);
   localparam int unsigned OCW = $clog2(N_BUF + 1);
   localparam int unsigned GCW = $clog2(PKT_NIBS + 1);

   logic [SCW-1:0] shifts;
   logic [OCW-1:0] occ;
   logic [GCW-1:0] seg;
   logic           take, give;

   assign take = in_valid && in_ready && (rx_idx == '0);
   assign give = out_valid && (seg == GCW'(PKT_NIBS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shifts <= '0;
         occ    <= '0;
         seg    <= '0;
      end else begin
         if (tbl_shift_en && shifts != SCW'(TBL_BITS)) shifts <= shifts + 1'b1;
         occ <= occ + OCW'(take) - OCW'(give);
         if (out_valid) seg <= (seg == GCW'(PKT_NIBS)) ? GCW'(1) : seg + 1'b1;
         else           seg <= '0;
      end
   end

   assert_ready_unloaded_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (shifts != SCW'(TBL_BITS)) |-> !in_ready);

   assert_midpkt_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_idx != '0) |-> in_ready);

   assert_pool_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == OCW'(N_BUF) && rx_idx == '0) |-> !in_ready);

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCW'(N_BUF));

   assert_run_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_valid && seg != '0) |-> (seg == GCW'(PKT_NIBS)));

   assert_grant_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(grant_valid && q_nonempty[grant_q]));
endmodule

bind voq_input_port voq_input_port_chk #(
   .PKT_NIBS (PKT_NIBS),
   .N_BUF    (N_BUF),
   .N_Q      (N_OUT * N_PRIO),
   .TBL_BITS ((1 << NIB_W) * $clog2(N_OUT)),
   .IW       ($clog2(PKT_NIBS))
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tbl_shift_en (tbl_shift_en),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .rx_idx       (rx_idx),
   .out_valid    (out_valid),
   .grant_valid  (grant_valid),
   .grant_q      (grant_q),
   .q_nonempty   (q_nonempty)
);

// File: tb/tb_voq_input_port.sv
`timescale 1ns/1ps
module tb_voq_input_port;
   localparam int NQ = 8;
   localparam int NB = 16;
   localparam int PN = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tbl_shift_en = 1'b0;
   logic       tbl_shift_bit = 1'b0;
   logic       in_valid = 1'b0;
   logic [3:0] in_nib = '0;
   logic       in_ready;
   logic [7:0] q_nonempty;
   logic       grant_valid = 1'b0;
   logic [2:0] grant_q = '0;
   logic       out_valid;
   logic [3:0] out_nib;

   voq_input_port dut (
      .clk(clk), .rst_n(rst_n), .tbl_shift_en(tbl_shift_en), .tbl_shift_bit(tbl_shift_bit),
      .in_valid(in_valid), .in_nib(in_nib), .in_ready(in_ready), .q_nonempty(q_nonempty),
      .grant_valid(grant_valid), .grant_q(grant_q), .out_valid(out_valid), .out_nib(out_nib)
   );

   always #4 clk = ~clk;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;
   int rtab [16];
   logic [3:0] mq [NQ][NB][PN];
   int mq_wr [NQ];
   int mq_rd [NQ];
   int mq_cnt [NQ];

   function automatic int qsel(input int dest, input int prio);
      return 2 * rtab[dest] + prio;
   endfunction

   function automatic logic [7:0] exp_flags();
      logic [7:0] f;
      for (int q = 0; q < NQ; q++) f[q] = (mq_cnt[q] != 0);
      return f;
   endfunction

   function automatic int stored();
      int s = 0;
      for (int q = 0; q < NQ; q++) s += mq_cnt[q];
      return s;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send_pkt(input int dest, input int prio, input bit gaps);
      logic [3:0] nb [PN];
      logic [3:0] t;
      int i = 0;
      int tries = 0;
      bit mid_bad = 1'b0;
      bit acc;
      int q;
      nb[0] = 4'(dest);
      t = 4'($urandom);
      t[0] = prio[0];
      nb[1] = t;
      for (int k = 2; k < PN; k++) nb[k] = 4'($urandom);
      while (i < PN && tries < 200) begin
         @(negedge clk);
         tries++;
         if (gaps && i > 0 && ($urandom % 4) == 0) begin
            in_valid = 1'b0;
            if (!in_ready) mid_bad = 1'b1;
            @(posedge clk);
         end else begin
            in_valid = 1'b1;
            in_nib = nb[i];
            if (i > 0 && !in_ready) mid_bad = 1'b1;
            acc = in_ready;
            @(posedge clk);
            if (acc) i++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      chk(!mid_bad && i == PN, "R8 mid-packet ready", i, PN);
      q = qsel(dest, prio);
      for (int k = 0; k < PN; k++) mq[q][mq_wr[q]][k] = nb[k];
      mq_wr[q] = (mq_wr[q] + 1) % NB;
      mq_cnt[q]++;
      chk(q_nonempty == exp_flags(), "R3 R4 queue flags", q_nonempty, exp_flags());
   endtask

   task automatic start_grant(input int q);
      @(negedge clk);
      grant_valid = 1'b1;
      grant_q = 3'(q);
      @(negedge clk);
      grant_valid = 1'b0;
   endtask

   task automatic stream(input int q, input int chain_q, input int busy_q, input bit watch,
                         output bit chained);
      logic [3:0] e [PN];
      for (int k = 0; k < PN; k++) e[k] = mq[q][mq_rd[q]][k];
      mq_rd[q] = (mq_rd[q] + 1) % NB;
      mq_cnt[q]--;
      chained = 1'b0;
      for (int i = 0; i < PN; i++) begin
         chk(out_valid && out_nib == e[i], "R5 R6 output nibble", int'(out_nib), int'(e[i]));
         if (watch) chk(in_ready == 1'b0, "R9 held buffer", in_ready, 0);
         if (busy_q >= 0 && i == 3) begin
            grant_valid = 1'b1;
            grant_q = 3'(busy_q);
         end
         if (i == 4) grant_valid = 1'b0;
         if (chain_q >= 0 && i == PN - 1) begin
            grant_valid = 1'b1;
            grant_q = 3'(chain_q);
            chained = (mq_cnt[chain_q] != 0);
         end
         @(negedge clk);
      end
      grant_valid = 1'b0;
      if (watch) chk(in_ready == 1'b1, "R9 release", in_ready, 1);
      if (!chained) begin
         chk(out_valid == 1'b0, (chain_q >= 0) ? "R7 chain to empty" : "R5 end of run", out_valid, 0);
         chk(q_nonempty == exp_flags(), "R4 R7 flags after send", q_nonempty, exp_flags());
      end
   endtask

   task automatic grant_any(input int q, input int chain_q, input int busy_q, input bit watch);
      bit ch;
      start_grant(q);
      if (mq_cnt[q] == 0) begin
         chk(out_valid == 1'b0, "R7 empty grant", out_valid, 0);
         chk(q_nonempty == exp_flags(), "R7 flags kept", q_nonempty, exp_flags());
         return;
      end
      stream(q, chain_q, busy_q, watch, ch);
      if (ch) begin
         chk(1'b1, "R10 chained start", 1, 1);
         stream(chain_q, -1, -1, 1'b0, ch);
      end
   endtask

   task automatic drain(input bit chain);
      int guard = 0;
      while (stored() > 0 && guard < 100) begin
         int a = -1;
         int b = -1;
         guard++;
         for (int q = 0; q < NQ; q++) if (mq_cnt[q] > 0 && a < 0) a = q;
         for (int q = NQ - 1; q >= 0; q--) if (mq_cnt[q] > 0 && b < 0) b = q;
         if (a == b && mq_cnt[a] < 2) b = -1;
         grant_any(a, chain ? b : -1, -1, 1'b0);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL R5 watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end

   initial begin : main
      int n;
      void'($urandom(32'd7319));
      for (int q = 0; q < NQ; q++) begin
         mq_wr[q] = 0;
         mq_rd[q] = 0;
         mq_cnt[q] = 0;
      end
      for (int k = 0; k < 16; k++) rtab[k] = int'($urandom % 4);
      rtab[3] = 2;
      rtab[12] = 1;

      repeat (3) @(posedge clk);
      chk(in_ready == 1'b0 && out_valid == 1'b0 && q_nonempty == 8'h00, "R1 during reset",
          {in_ready, out_valid, q_nonempty}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b0 && out_valid == 1'b0 && q_nonempty == 8'h00, "R1 after reset",
          {in_ready, out_valid, q_nonempty}, 0);

      // serial table load, entry 0 low bit first
      n = 0;
      for (int k = 0; k < 16; k++) begin
         for (int b = 0; b < 2; b++) begin
            if (n == 31) chk(in_ready == 1'b0, "R2 ready before last shift", in_ready, 0);
            tbl_shift_en = 1'b1;
            tbl_shift_bit = 1'((rtab[k] >> b) & 1);
            n++;
            @(negedge clk);
         end
      end
      tbl_shift_en = 1'b0;
      chk(in_ready == 1'b1, "R2 ready after load", in_ready, 1);

      // directed routing: two priorities to one output, table entries 3 and 12
      send_pkt(3, 0, 1'b0);
      send_pkt(3, 1, 1'b0);
      send_pkt(12, 1, 1'b1);
      send_pkt(3, 0, 1'b1);
      grant_any(qsel(3, 0), -1, qsel(3, 1), 1'b0);
      grant_any(qsel(3, 0), -1, -1, 1'b0);
      grant_any(qsel(3, 0), -1, -1, 1'b0);

      // constrained random mix
      for (int it = 0; it < 80; it++) begin
         if (stored() < NB && (($urandom % 2) == 0 || stored() == 0)) begin
            send_pkt(int'($urandom % 16), int'($urandom % 2), 1'($urandom));
         end else begin
            int gq = int'($urandom % 8);
            int cq = -1;
            int bq = -1;
            if (($urandom % 3) == 0) cq = int'($urandom % 8);
            if (($urandom % 4) == 0) bq = int'($urandom % 8);
            grant_any(gq, cq, bq, 1'b0);
         end
      end
      drain(1'b0);

      // pool exhaustion and release timing
      for (int k = 0; k < NB - 1; k++) send_pkt(int'($urandom % 16), int'($urandom % 2), 1'b0);
      chk(in_ready == 1'b1, "R8 one buffer left", in_ready, 1);
      send_pkt(int'($urandom % 16), int'($urandom % 2), 1'b1);
      chk(in_ready == 1'b0, "R8 pool full", in_ready, 0);
      @(negedge clk);
      in_valid = 1'b1;
      in_nib = 4'h5;
      repeat (4) @(negedge clk);
      in_valid = 1'b0;
      chk(q_nonempty == exp_flags() && in_ready == 1'b0, "R8 offer while full ignored",
          q_nonempty, exp_flags());
      begin
         int fq = -1;
         for (int q = 0; q < NQ; q++) if (mq_cnt[q] > 0 && fq < 0) fq = q;
         grant_any(fq, -1, -1, 1'b1);
      end
      send_pkt(int'($urandom % 16), int'($urandom % 2), 1'b0);
      chk(in_ready == 1'b0, "R8 full again", in_ready, 0);

      // back-to-back drain
      drain(1'b1);
      chk(q_nonempty == 8'h00 && out_valid == 1'b0, "R4 all empty", q_nonempty, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule